// File: doc/BRIEF.md
# Legacy UART Register and Interrupt Unit

This block is the host-facing register file of a 16450-style serial controller. A host bus reaches eight byte-wide registers through a three-bit offset, using single-cycle read and write strobes. The block holds the baud divisor, the interrupt enables, the line and modem control settings and a scratch byte. It also holds the last received character with its ready and break flags. From that state it derives a prioritised interrupt identification code and a registered interrupt level.

The bit-level serial engine sits beside it. The engine takes a one-cycle transmit strobe with the byte written by the host. It returns received characters and break conditions as single-cycle strobes. The divisor, the line control byte and the modem control bits are exported for the engine. With the loop bit set in modem control, the modem status register shows the control outputs rather than the fixed idle line state.

Top module: `uart_regfile`

## Requirements
- R1: After reset, offset 5 (line status) reads 0x60, offset 2 (identification) reads 0x01, offset 6 (modem status) reads 0xB0, all other offsets read 0x00, and `irq` is low.
- R2: While line control bit 7 is set, writes and reads at offset 0 and offset 1 reach the low and high divisor bytes (`divisor_o` = {high, low}). No transmit strobe is issued, and the interrupt-enable register is left unchanged.
- R3: Identification reads 0x04 when data-ready (line status bit 0) and enable bit 0 are both set. Otherwise it reads 0x02 when the transmit-pending flag and enable bit 1 are both set, and 0x01 in all other cases. `irq` is high exactly when identification is not 0x01.
- R4: A read of offset 2 that returns 0x02 clears the transmit-pending flag. A read that returns any other code leaves the flag as it was.
- R5: A write to offset 1 outside divisor mode stores bits 3:0 only, so bits 7:4 read back as 0. The same write sets the transmit-pending flag.
- R6: A write to offset 0 outside divisor mode raises `tx_strobe` for exactly the next cycle with `tx_byte` equal to the written value. It sets the transmit-pending flag, and line status bits 5 and 6 stay set.
- R7: A read of offset 0 outside divisor mode returns the held received byte and clears line status bits 0 (data ready) and 4 (break).
- R8: A `rx_valid` strobe loads `rx_byte` and sets data ready. A `rx_break` strobe loads 0x00 and sets both break and data ready, so line status reads 0x71.
- R9: With modem control bit 4 set, modem status reads control bits 3:2 in bits 7:6, control bit 0 in bit 5, control bit 1 in bit 4, and zeros in bits 3:0. With bit 4 clear, modem status reads 0xB0.
- R10: Modem control keeps bits 4:0 only. Line control (offset 3) and scratch (offset 7) store all eight bits. Writes to offsets 2, 5 and 6 change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe; read side effects take place at its clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| irq | output | 1 | Registered interrupt level |
| tx_strobe | output | 1 | One-cycle pulse: a byte is to be sent |
| tx_byte | output | 8 | Byte to send, valid while `tx_strobe` is high |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | One-cycle pulse: a break was received |
| divisor_o | output | 16 | Baud divisor |
| line_ctrl_o | output | 8 | Line control byte |
| modem_ctrl_o | output | 5 | Modem control bits |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` together. They also assume that `rx_valid` and `rx_break` never arrive in the same cycle as a data-register read, because either of those events would override the clearing of the ready flag. The stimulus drives each bus access or receive event as a separate pulse with an idle cycle after it, so these combinations never occur. The bench keeps its own model of the ready, break, pending and enable state, and derives the identification code and interrupt level from that model.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam logic [DATA_W-1:0] IID_NONE   = 8'h01;
  localparam logic [DATA_W-1:0] IID_TXE    = 8'h02;
  localparam logic [DATA_W-1:0] IID_RXD    = 8'h04;
  localparam logic [DATA_W-1:0] MSTAT_IDLE = 8'hB0;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic         rx_break,
  input  logic [W-1:0] rx_byte,
  input  logic         data_read,
  output logic [W-1:0] rbr_q,
  output logic         rdy_q,
  output logic         brk_q,
  output logic         rdy_d
);
  logic [W-1:0] rbr_d;
  logic         brk_d;

  // Order sets the priority: break, then byte, then the read clearing.
  always_comb begin
    rbr_d = rbr_q;
    rdy_d = rdy_q;
    brk_d = brk_q;
    if (data_read) begin
      rdy_d = 1'b0;
      brk_d = 1'b0;
    end
    if (rx_valid) begin
      rbr_d = rx_byte;
      rdy_d = 1'b1;
    end
    if (rx_break) begin
      rbr_d = '0;
      rdy_d = 1'b1;
      brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0;
      rdy_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      rbr_q <= rbr_d;
      rdy_q <= rdy_d;
      brk_q <= brk_d;
    end
  end

  p_break_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (rbr_q == '0) && rdy_q && brk_q);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !rx_valid && !rx_break) |=> !rdy_q && !brk_q);
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_reg_pkg::*;
#(
  parameter int IEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_q,
  input  logic              rdy_d,
  input  logic [IEN_W-1:0]  ien_q,
  input  logic [IEN_W-1:0]  ien_d,
  input  logic              arm_pend,
  input  logic              iid_read,
  output logic [DATA_W-1:0] iid,
  output logic              irq
);
  logic thr_pend_q, thr_pend_d;
  logic irq_d;

  always_comb begin
    if (rdy_q && ien_q[0])           iid = IID_RXD;
    else if (thr_pend_q && ien_q[1]) iid = IID_TXE;
    else                             iid = IID_NONE;
  end

  always_comb begin
    thr_pend_d = thr_pend_q;
    if (iid_read && (iid == IID_TXE)) thr_pend_d = 1'b0;
    if (arm_pend)                     thr_pend_d = 1'b1;
    irq_d = (rdy_d && ien_d[0]) || (thr_pend_d && ien_d[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pend_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      thr_pend_q <= thr_pend_d;
      irq        <= irq_d;
    end
  end

  p_irq_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid != IID_NONE));

  p_txe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_read && (iid == IID_TXE) && !arm_pend) |=> !thr_pend_q);

  p_arm_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pend |=> thr_pend_q);
endmodule

// File: rtl/uart_modem_view.sv
module uart_modem_view
  import uart_reg_pkg::*;
#(
  parameter int MCTL_W = 5
) (
  input  logic [MCTL_W-1:0] mctl,
  output logic [DATA_W-1:0] mstat
);
  localparam int LOOP_BIT = MCTL_W - 1;

  always_comb begin
    if (mctl[LOOP_BIT]) mstat = {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0000};
    else                mstat = MSTAT_IDLE;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq,
  output logic                tx_strobe,
  output logic [DATA_W-1:0]   tx_byte,
  input  logic                rx_valid,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic                rx_break,
  output logic [2*DATA_W-1:0] divisor_o,
  output logic [DATA_W-1:0]   line_ctrl_o,
  output logic [MCTL_W-1:0]   modem_ctrl_o
);
  localparam int DLAB_BIT = DATA_W - 1;

  reg_ofs_e ofs;
  logic dlab;
  logic wr_tx, wr_dlo, wr_dhi, wr_ien, wr_lctl, wr_mctl, wr_scr;
  logic rd_data, rd_iid;

  logic [DATA_W-1:0] div_lo_q, div_lo_d, div_hi_q, div_hi_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [DATA_W-1:0] lctl_q, lctl_d, scr_q, scr_d;
  logic [MCTL_W-1:0] mctl_q, mctl_d;
  logic              tx_stb_d;
  logic [DATA_W-1:0] tx_byte_d;

  logic [DATA_W-1:0] rbr_q, iid, mstat, lstat;
  logic rdy_q, brk_q, rdy_d;

  assign ofs  = reg_ofs_e'(bus_addr);
  assign dlab = lctl_q[DLAB_BIT];

  always_comb begin
    wr_tx   = bus_wr && (ofs == OFS_DATA) && !dlab;
    wr_dlo  = bus_wr && (ofs == OFS_DATA) && dlab;
    wr_dhi  = bus_wr && (ofs == OFS_IEN)  && dlab;
    wr_ien  = bus_wr && (ofs == OFS_IEN)  && !dlab;
    wr_lctl = bus_wr && (ofs == OFS_LCTL);
    wr_mctl = bus_wr && (ofs == OFS_MCTL);
    wr_scr  = bus_wr && (ofs == OFS_SCR);
    rd_data = bus_rd && (ofs == OFS_DATA) && !dlab;
    rd_iid  = bus_rd && (ofs == OFS_IID);
  end

  // Next-state logic
  always_comb begin
    div_lo_d  = wr_dlo  ? bus_wdata : div_lo_q;
    div_hi_d  = wr_dhi  ? bus_wdata : div_hi_q;
    ien_d     = wr_ien  ? bus_wdata[IEN_W-1:0] : ien_q;
    lctl_d    = wr_lctl ? bus_wdata : lctl_q;
    mctl_d    = wr_mctl ? bus_wdata[MCTL_W-1:0] : mctl_q;
    scr_d     = wr_scr  ? bus_wdata : scr_q;
    tx_stb_d  = wr_tx;
    tx_byte_d = wr_tx   ? bus_wdata : tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q  <= '0;
      div_hi_q  <= '0;
      ien_q     <= '0;
      lctl_q    <= '0;
      mctl_q    <= '0;
      scr_q     <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      div_lo_q  <= div_lo_d;
      div_hi_q  <= div_hi_d;
      ien_q     <= ien_d;
      lctl_q    <= lctl_d;
      mctl_q    <= mctl_d;
      scr_q     <= scr_d;
      tx_strobe <= tx_stb_d;
      tx_byte   <= tx_byte_d;
    end
  end

  uart_rx_hold #(.W(DATA_W)) u_rx_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rx_byte   (rx_byte),
    .data_read (rd_data),
    .rbr_q     (rbr_q),
    .rdy_q     (rdy_q),
    .brk_q     (brk_q),
    .rdy_d     (rdy_d)
  );

  // The holding register empties at once, so a data or enable write re-arms.
  uart_irq_unit #(.IEN_W(IEN_W)) u_irq_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_q    (rdy_q),
    .rdy_d    (rdy_d),
    .ien_q    (ien_q),
    .ien_d    (ien_d),
    .arm_pend (wr_tx || wr_ien),
    .iid_read (rd_iid),
    .iid      (iid),
    .irq      (irq)
  );

  uart_modem_view #(.MCTL_W(MCTL_W)) u_modem_view (
    .mctl  (mctl_q),
    .mstat (mstat)
  );

  assign lstat = {1'b0, 1'b1, 1'b1, brk_q, 3'b000, rdy_q};

  always_comb begin
    unique case (ofs)
      OFS_DATA:  bus_rdata = dlab ? div_lo_q : rbr_q;
      OFS_IEN:   bus_rdata = dlab ? div_hi_q : {{(DATA_W-IEN_W){1'b0}}, ien_q};
      OFS_IID:   bus_rdata = iid;
      OFS_LCTL:  bus_rdata = lctl_q;
      OFS_MCTL:  bus_rdata = {{(DATA_W-MCTL_W){1'b0}}, mctl_q};
      OFS_LSTAT: bus_rdata = lstat;
      OFS_MSTAT: bus_rdata = mstat;
      OFS_SCR:   bus_rdata = scr_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign divisor_o    = {div_hi_q, div_lo_q};
  assign line_ctrl_o  = lctl_q;
  assign modem_ctrl_o = mctl_q;

  p_tx_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_DATA) && !lctl_q[DLAB_BIT])
      |=> tx_strobe && (tx_byte == $past(bus_wdata)));

  p_div_no_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_DATA) && lctl_q[DLAB_BIT]) |=> !tx_strobe);

  p_txe_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_LSTAT) |-> (bus_rdata[6:5] == 2'b11));
endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, tx_strobe;
  logic [7:0] tx_byte;
  logic       rx_valid, rx_break;
  logic [7:0] rx_byte;
  logic [15:0] divisor_o;
  logic [7:0] line_ctrl_o;
  logic [4:0] modem_ctrl_o;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  // Bench model of the requirement state
  bit       m_rdy, m_brk, m_pend;
  bit [3:0] m_ien;
  bit [7:0] m_rbr;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .divisor_o(divisor_o), .line_ctrl_o(line_ctrl_o),
    .modem_ctrl_o(modem_ctrl_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_iid();
    if (m_rdy && m_ien[0])       return 8'h04;
    else if (m_pend && m_ien[1]) return 8'h02;
    else                         return 8'h01;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit brk);
    @(negedge clk);
    if (brk) rx_break = 1'b1; else begin rx_valid = 1'b1; rx_byte = d; end
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
    m_rbr = brk ? 8'h00 : d; m_rdy = 1; if (brk) m_brk = 1;
  endtask

  // Reads identification and checks it and irq against the model (R3, R4)
  task automatic check_iid(input string tag);
    logic [7:0] v, e;
    e = exp_iid();
    chk({tag, " irq R3"}, {15'd0, irq}, {15'd0, (e != 8'h01)});
    bus_read(3'd2, v);
    chk({tag, " iid R3"}, {8'd0, v}, {8'd0, e});
    if (e == 8'h02) m_pend = 0;
  endtask

  task automatic read_data_model(input string tag);
    logic [7:0] v;
    bus_read(3'd0, v);
    chk({tag, " data R7"}, {8'd0, v}, {8'd0, m_rbr});
    m_rdy = 0; m_brk = 0;
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    rx_valid = 0; rx_break = 0; rx_byte = '0;
    m_rdy = 0; m_brk = 0; m_pend = 0; m_ien = 0; m_rbr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("reset irq R1", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 8; a++) begin
      bus_read(a[2:0], v);
      chk($sformatf("reset ofs%0d R1", a), {8'd0, v},
          (a == 2) ? 16'h01 : (a == 5) ? 16'h60 : (a == 6) ? 16'hB0 : 16'h00);
    end

    // R10 scratch and line control full sweeps
    for (int i = 0; i < 256; i++) begin
      bus_write(3'd7, i[7:0]);
      bus_read(3'd7, v);
      chk("scratch R10", {8'd0, v}, i[15:0]);
    end
    for (int i = 0; i < 256; i++) begin
      bus_write(3'd3, i[7:0]);
      bus_read(3'd3, v);
      chk("lctl R10", {8'd0, v}, i[15:0]);
      chk("lctl out R10", {8'd0, line_ctrl_o}, i[15:0]);
    end
    bus_write(3'd3, 8'h00);

    // R2 divisor banking
    bus_write(3'd3, 8'h80);
    for (int i = 0; i < 256; i++) begin
      bus_write(3'd0, i[7:0]);
      chk("div no tx R2", {15'd0, tx_strobe}, 16'd0);
      bus_write(3'd1, 8'(255 - i));
      chk("divisor out R2", divisor_o, {8'(255 - i), i[7:0]});
      bus_read(3'd0, v);
      chk("div lo R2", {8'd0, v}, i[15:0]);
      bus_read(3'd1, v);
      chk("div hi R2", {8'd0, v}, 16'(255 - i));
    end
    bus_write(3'd3, 8'h00);
    bus_read(3'd1, v);
    chk("ien untouched R2", {8'd0, v}, 16'h00);
    check_iid("after div");

    // R3/R4/R5 enable sweep with and without received data
    for (int e = 0; e < 16; e++) begin
      for (int d = 0; d < 2; d++) begin
        bus_write(3'd1, 8'hF0 | e[7:0]);
        m_ien = e[3:0]; m_pend = 1;
        bus_read(3'd1, v);
        chk("ien mask R5", {8'd0, v}, 16'(e));
        if (d == 1) send_rx(8'(e * 17 + 3), 0);
        check_iid("sweep first R4");
        check_iid("sweep second R4");
        if (d == 1) begin
          read_data_model("sweep");
          check_iid("sweep after read R3");
        end
      end
    end

    // R6 transmit sweep with transmit interrupt enabled
    bus_write(3'd1, 8'h02); m_ien = 4'h2; m_pend = 1;
    for (int i = 0; i < 256; i++) begin
      check_iid("tx pre R4");
      bus_write(3'd0, i[7:0]);
      m_pend = 1;
      chk("tx strobe R6", {15'd0, tx_strobe}, 16'd1);
      chk("tx byte R6", {8'd0, tx_byte}, i[15:0]);
      @(negedge clk);
      chk("tx strobe end R6", {15'd0, tx_strobe}, 16'd0);
      bus_read(3'd5, v);
      chk("tx lstat R6", {8'd0, v}, 16'h60);
      chk("tx irq R6", {15'd0, irq}, 16'd1);
    end

    // R7/R8 receive sweep
    bus_write(3'd1, 8'h01); m_ien = 4'h1; m_pend = 1;
    for (int i = 0; i < 256; i++) begin
      send_rx(i[7:0], 0);
      bus_read(3'd5, v);
      chk("rx lstat R8", {8'd0, v}, 16'h61);
      check_iid("rx R3");
      read_data_model("rx");
      bus_read(3'd5, v);
      chk("rx cleared R7", {8'd0, v}, 16'h60);
    end
    send_rx(8'h5A, 0);
    send_rx(8'h00, 1);
    bus_read(3'd5, v);
    chk("break lstat R8", {8'd0, v}, 16'h71);
    read_data_model("break R8");
    bus_read(3'd5, v);
    chk("break cleared R7", {8'd0, v}, 16'h60);

    // R9/R10 modem control sweep with loopback view
    for (int i = 0; i < 256; i++) begin
      logic [4:0] m;
      m = i[4:0];
      bus_write(3'd4, i[7:0]);
      bus_read(3'd4, v);
      chk("mctl mask R10", {8'd0, v}, {11'd0, m});
      chk("mctl out R10", {11'd0, modem_ctrl_o}, {11'd0, m});
      bus_read(3'd6, v);
      chk("mstat R9", {8'd0, v},
          m[4] ? 16'((m[3:2] << 6) | (m[0] << 5) | (m[1] << 4)) : 16'hB0);
    end
    bus_write(3'd4, 8'h00);

    // R10 writes to read-only offsets have no effect
    bus_write(3'd2, 8'hFF);
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'h00);
    bus_read(3'd5, v);
    chk("lstat ro R10", {8'd0, v}, 16'h60);
    bus_read(3'd6, v);
    chk("mstat ro R10", {8'd0, v}, 16'hB0);
    check_iid("iid ro R10");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule